// File: doc/BRIEF.md
# Colour Lookup Engine with Indirect Control Registers

This block sits between the pixel fetch and the output stage of a display pipeline and turns each pixel word into 24-bit RGB. A host loads a 256-entry colour palette through a shared byte-wide port: it first writes an entry number to the address port and then sends three colour bytes, red, green and blue, one per write, to the lookup port. An internal channel counter tracks which colour byte comes next. The entry is stored only when its blue byte arrives, and the entry number then advances by one, so a whole palette can be streamed after a single address write.

The same address register also selects a small set of indirect control registers, which the host writes through a separate data port. One register holds the pixel-format control value and another chooses the memory bank that feeds the display. The format value selects one of three pixel interpretations. An 8-bit pixel is a palette index. A 16-bit pixel is direct 5-5-5 colour, and each 5-bit channel is widened to 8 bits. A 32-bit pixel is direct 8-8-8 colour whose top byte is ignored. Each valid pixel presented on one clock edge gives its RGB result after that edge.

Top module: `colour_lut`

## Requirements
- R1: After synchronous reset, fmt_ctrl is 0x10 (indexed, single bank), bank_sel is 0, pix_rgb_valid is 0 and pix_rgb is 0. The palette contents are undefined until they are loaded.
- R2: host_sel encodes the port: 0 is the address port, 1 is the lookup port, 2 is the register data port and 3 is unused, so writes to it are ignored. An address write followed by three lookup writes, in the order red, green, blue, stores that colour in the addressed entry. In indexed mode, pixel index i then reads back as red in pix_rgb[23:16], green in [15:8] and blue in [7:0].
- R3: Each blue byte advances the current entry number by one. From entry 255 it wraps to 0, so consecutive triples fill consecutive entries.
- R4: A write to the address port resets the channel counter to red. A partly sent triple is dropped and the entry it was aimed at keeps its old contents.
- R5: A data-port write while the current address is 0x20 loads fmt_ctrl. Bits 3:2 of fmt_ctrl select the format: 00 is indexed, 01 is 5-5-5, 10 is 8-8-8 and 11 is indexed. So 0x10 and 0x20 select indexed, 0x14 and 0x24 select 5-5-5, and 0x18 and 0x28 select 8-8-8.
- R6: A data-port write while the current address is 0x21 copies bit 0 of the written byte to bank_sel.
- R7: Data-port writes to any other register number, including 0x10 and 0x11, leave fmt_ctrl and bank_sel unchanged.
- R8: In 5-5-5 mode red is taken from pixel bits 14:10, green from 9:5 and blue from 4:0. Each channel v becomes {v, v[4:2]}, and pixel bits 31:15 are ignored.
- R9: In 8-8-8 mode pix_rgb equals pixel bits 23:0, and bits 31:24 have no effect.
- R10: pix_rgb_valid goes high one cycle after a cycle with pix_valid high, and the matching result is on pix_rgb in that cycle. When pix_rgb_valid is low, pix_rgb is 0.
- R11: If a blue-byte write and an indexed lookup of the same entry fall on the same clock edge, the lookup returns the entry's previous contents. A lookup on the next edge returns the new colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe, one write per cycle |
| host_sel | input | 2 | Port select: 0 address, 1 lookup, 2 register data, 3 unused |
| host_wdata | input | 8 | Host write byte |
| pix_valid | input | 1 | Pixel word present this cycle |
| pix_data | input | 32 | Pixel word |
| pix_rgb_valid | output | 1 | RGB result valid |
| pix_rgb | output | 24 | Result colour {red, green, blue} |
| fmt_ctrl | output | 8 | Pixel-format control register (indirect register 0x20) |
| bank_sel | output | 1 | Display memory bank select (indirect register 0x21) |

## Verification
A palette commit and an indexed lookup can happen on the same clock edge. This matters most when both target the same entry. The bench provokes it by holding back the blue byte of an entry and sending it in the same cycle as a pixel whose index is that entry. The result must be the entry's old colour, and a repeat lookup one cycle later must give the new colour. Random palette loads and random pixels in all three formats run alongside this directed case, and each result is compared with a shadow palette kept by the bench.

// File: rtl/colour_lut_pkg.sv
package colour_lut_pkg;

    localparam int CH_W     = 8;
    localparam int HOST_W   = 8;
    localparam int IDX_W    = 8;
    localparam int ENTRIES  = 1 << IDX_W;
    localparam int PIX_W    = 32;
    localparam int RGB_W    = 3 * CH_W;
    localparam int NARROW_W = 5;

    typedef enum logic [1:0] {
        PORT_ADDR = 2'd0,
        PORT_LUT  = 2'd1,
        PORT_REG  = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;

    typedef enum logic [1:0] {
        FMT_IDX8   = 2'd0,
        FMT_RGB555 = 2'd1,
        FMT_RGB888 = 2'd2,
        FMT_RSVD   = 2'd3
    } pixfmt_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    localparam logic [HOST_W-1:0] REG_FMT   = 8'h20;
    localparam logic [HOST_W-1:0] REG_BANK  = 8'h21;
    localparam logic [HOST_W-1:0] FMT_RESET = 8'h10;

    // Widen a narrow channel by repeating its top bits below it.
    function automatic logic [CH_W-1:0] widen_chan(input logic [NARROW_W-1:0] v);
        return {v, v[NARROW_W-1 -: (CH_W-NARROW_W)]};
    endfunction

    function automatic pixfmt_e fmt_decode(input logic [HOST_W-1:0] ctrl);
        return pixfmt_e'(ctrl[3:2]);
    endfunction

endpackage

// File: rtl/clut_host_port.sv
module clut_host_port
    import colour_lut_pkg::*;
#(
    parameter int AW = HOST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [HOST_W-1:0] wdata,
    output logic              pal_we,
    output logic [AW-1:0]     pal_waddr,
    output rgb_t              pal_wdata,
    output logic [HOST_W-1:0] fmt_ctrl,
    output logic              bank_sel,
    output logic [AW-1:0]     cur_addr,
    output logic [1:0]        cur_chan
);

    logic [AW-1:0]   addr_q;
    chan_e           chan_q;
    logic [CH_W-1:0] red_q;
    logic [CH_W-1:0] grn_q;
    logic [HOST_W-1:0] fmt_q;
    logic            bank_q;
    port_e           port;

    assign port = port_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            chan_q <= CH_RED;
            red_q  <= '0;
            grn_q  <= '0;
            fmt_q  <= FMT_RESET;
            bank_q <= 1'b0;
        end else if (wr_en) begin
            case (port)
                PORT_ADDR: begin
                    addr_q <= wdata[AW-1:0];
                    chan_q <= CH_RED;
                end
                PORT_LUT: begin
                    case (chan_q)
                        CH_RED: begin
                            red_q  <= wdata;
                            chan_q <= CH_GREEN;
                        end
                        CH_GREEN: begin
                            grn_q  <= wdata;
                            chan_q <= CH_BLUE;
                        end
                        default: begin
                            chan_q <= CH_RED;
                            addr_q <= addr_q + 1'b1;
                        end
                    endcase
                end
                PORT_REG: begin
                    if (addr_q == REG_FMT[AW-1:0])
                        fmt_q <= wdata;
                    if (addr_q == REG_BANK[AW-1:0])
                        bank_q <= wdata[0];
                end
                default: ;
            endcase
        end
    end

    assign pal_we    = wr_en && (port == PORT_LUT) && (chan_q == CH_BLUE);
    assign pal_waddr = addr_q;
    assign pal_wdata = '{r: red_q, g: grn_q, b: wdata};
    assign fmt_ctrl  = fmt_q;
    assign bank_sel  = bank_q;
    assign cur_addr  = addr_q;
    assign cur_chan  = chan_q;

endmodule

// File: rtl/clut_palette.sv
module clut_palette
    import colour_lut_pkg::*;
#(
    parameter int AW    = IDX_W,
    parameter int DEPTH = ENTRIES
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rgb_t          wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output rgb_t          rdata
);

    rgb_t mem [DEPTH];
    rgb_t rd_q;

    // Read and write on one edge: the read samples the stored value before the update.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        if (re)
            rd_q <= mem[raddr];
    end

    assign rdata = rd_q;

endmodule

// File: rtl/clut_pixel_expand.sv
module clut_pixel_expand
    import colour_lut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic [HOST_W-1:0] fmt_ctrl,
    input  rgb_t              pal_rdata,
    output logic              out_valid,
    output rgb_t              out_rgb
);

    logic [CH_W-1:0] wide [3];
    rgb_t            c555;
    rgb_t            c888;
    rgb_t            direct_q;
    pixfmt_e         fmt_now;
    pixfmt_e         fmt_q;
    logic            valid_q;
    logic            unused_alpha;
    logic            unused_fmt_bits;

    // Index 0 is blue, 1 is green, 2 is red.
    for (genvar c = 0; c < 3; c++) begin : g_widen
        assign wide[c] = widen_chan(pix_data[c*NARROW_W +: NARROW_W]);
    end

    assign c555    = '{r: wide[2], g: wide[1], b: wide[0]};
    assign c888    = rgb_t'(pix_data[RGB_W-1:0]);
    assign fmt_now = fmt_decode(fmt_ctrl);

    assign unused_alpha    = ^pix_data[PIX_W-1:RGB_W];
    assign unused_fmt_bits = ^{fmt_ctrl[HOST_W-1:4], fmt_ctrl[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            fmt_q    <= FMT_IDX8;
            direct_q <= '0;
        end else begin
            valid_q <= pix_valid;
            if (pix_valid) begin
                fmt_q    <= fmt_now;
                direct_q <= (fmt_now == FMT_RGB555) ? c555 : c888;
            end
        end
    end

    always_comb begin
        out_rgb = '0;
        if (valid_q) begin
            case (fmt_q)
                FMT_RGB555,
                FMT_RGB888: out_rgb = direct_q;
                default:    out_rgb = pal_rdata;
            endcase
        end
    end

    assign out_valid = valid_q;

endmodule

// File: rtl/colour_lut.sv
module colour_lut
    import colour_lut_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_wr_en,
    input  logic [1:0]           host_sel,
    input  logic [HOST_W-1:0]    host_wdata,
    input  logic                 pix_valid,
    input  logic [PIX_W-1:0]     pix_data,
    output logic                 pix_rgb_valid,
    output logic [RGB_W-1:0]     pix_rgb,
    output logic [HOST_W-1:0]    fmt_ctrl,
    output logic                 bank_sel
);

    logic              pal_we;
    logic [IDX_W-1:0]  pal_waddr;
    rgb_t              pal_wdata;
    rgb_t              pal_rdata;
    rgb_t              out_rgb;
    logic [HOST_W-1:0] cur_addr;
    logic [1:0]        cur_chan;

    clut_host_port #(.AW(HOST_W)) u_host (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_wr_en),
        .sel      (host_sel),
        .wdata    (host_wdata),
        .pal_we   (pal_we),
        .pal_waddr(pal_waddr),
        .pal_wdata(pal_wdata),
        .fmt_ctrl (fmt_ctrl),
        .bank_sel (bank_sel),
        .cur_addr (cur_addr),
        .cur_chan (cur_chan)
    );

    clut_palette #(.AW(IDX_W), .DEPTH(ENTRIES)) u_pal (
        .clk  (clk),
        .we   (pal_we),
        .waddr(pal_waddr),
        .wdata(pal_wdata),
        .re   (pix_valid),
        .raddr(pix_data[IDX_W-1:0]),
        .rdata(pal_rdata)
    );

    clut_pixel_expand u_exp (
        .clk      (clk),
        .rst      (rst),
        .pix_valid(pix_valid),
        .pix_data (pix_data),
        .fmt_ctrl (fmt_ctrl),
        .pal_rdata(pal_rdata),
        .out_valid(pix_rgb_valid),
        .out_rgb  (out_rgb)
    );

    assign pix_rgb = out_rgb;

endmodule

// File: rtl/colour_lut_chk.sv
module colour_lut_chk
    import colour_lut_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 host_wr_en,
    input logic [1:0]           host_sel,
    input logic [HOST_W-1:0]    host_wdata,
    input logic                 pix_valid,
    input logic [PIX_W-1:0]     pix_data,
    input logic                 pix_rgb_valid,
    input logic [RGB_W-1:0]     pix_rgb,
    input logic [HOST_W-1:0]    fmt_ctrl,
    input logic                 bank_sel,
    input logic [HOST_W-1:0]    cur_addr,
    input logic [1:0]           cur_chan
);

    // R3
    blue_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_sel == 2'd1 && cur_chan == 2'd2)
        |=> (cur_addr == $past(cur_addr) + 8'd1) && (cur_chan == 2'd0));

    // R4
    addr_resets_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_sel == 2'd0) |=> (cur_chan == 2'd0));

    // R6
    bank_load_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_sel == 2'd2 && cur_addr == 8'h21)
        |=> (bank_sel == $past(host_wdata[0])));

    // R7
    other_reg_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_sel == 2'd2 && cur_addr != 8'h20 && cur_addr != 8'h21)
        |=> ($stable(fmt_ctrl) && $stable(bank_sel)));

    // R8
    rgb555_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && fmt_ctrl[3:2] == 2'b01)
        |=> (pix_rgb == {$past(pix_data[14:10]), $past(pix_data[14:12]),
                         $past(pix_data[9:5]),   $past(pix_data[9:7]),
                         $past(pix_data[4:0]),   $past(pix_data[4:2])}));

    // R9
    rgb888_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && fmt_ctrl[3:2] == 2'b10)
        |=> (pix_rgb == $past(pix_data[23:0])));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> pix_rgb_valid);

    // R10
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !pix_rgb_valid);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_rgb_valid |-> (pix_rgb == '0));

endmodule

bind colour_lut colour_lut_chk u_chk (.*);

// File: tb/tb_colour_lut.sv
`timescale 1ns/1ps
module tb_colour_lut;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr_en;
    logic [1:0]  host_sel;
    logic [7:0]  host_wdata;
    logic        pix_valid;
    logic [31:0] pix_data;
    logic        pix_rgb_valid;
    logic [23:0] pix_rgb;
    logic [7:0]  fmt_ctrl;
    logic        bank_sel;

    int checks = 0;
    int errors = 0;

    logic [23:0] m_pal [256];
    logic [7:0]  m_addr;
    logic [1:0]  m_chan;
    logic [7:0]  m_red, m_grn;
    logic [7:0]  m_fmt;
    logic        m_bank;

    always #2 clk = ~clk;

    colour_lut dut (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_sel(host_sel), .host_wdata(host_wdata),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_rgb_valid(pix_rgb_valid), .pix_rgb(pix_rgb),
        .fmt_ctrl(fmt_ctrl), .bank_sel(bank_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] w5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [23:0] exp_rgb(input logic [7:0] f, input logic [31:0] p);
        case (f[3:2])
            2'b01:   return {w5(p[14:10]), w5(p[9:5]), w5(p[4:0])};
            2'b10:   return p[23:0];
            default: return m_pal[p[7:0]];
        endcase
    endfunction

    task automatic model_write(input logic [1:0] s, input logic [7:0] d);
        case (s)
            2'd0: begin m_addr = d; m_chan = 2'd0; end
            2'd1: begin
                if (m_chan == 2'd0) begin m_red = d; m_chan = 2'd1; end
                else if (m_chan == 2'd1) begin m_grn = d; m_chan = 2'd2; end
                else begin
                    m_pal[m_addr] = {m_red, m_grn, d};
                    m_addr = m_addr + 8'd1;
                    m_chan = 2'd0;
                end
            end
            2'd2: begin
                if (m_addr == 8'h20) m_fmt = d;
                if (m_addr == 8'h21) m_bank = d[0];
            end
            default: ;
        endcase
    endtask

    // Entered and left at a falling edge.
    task automatic host_wr(input logic [1:0] s, input logic [7:0] d);
        host_wr_en = 1'b1; host_sel = s; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
        model_write(s, d);
    endtask

    task automatic set_reg(input logic [7:0] r, input logic [7:0] v);
        host_wr(2'd0, r);
        host_wr(2'd2, v);
    endtask

    task automatic pixel(input string req, input logic [31:0] p);
        logic [23:0] e;
        e = exp_rgb(m_fmt, p);
        pix_valid = 1'b1; pix_data = p;
        @(negedge clk);
        pix_valid = 1'b0;
        check({req, " valid"}, {31'd0, pix_rgb_valid}, 32'd1);
        check(req, {8'd0, pix_rgb}, {8'd0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] old_val;
        void'($urandom(32'h5eed_c01));
        rst = 1'b1; host_wr_en = 1'b0; host_sel = 2'd0; host_wdata = 8'd0;
        pix_valid = 1'b0; pix_data = 32'd0;
        m_addr = 8'd0; m_chan = 2'd0; m_red = 8'd0; m_grn = 8'd0;
        m_fmt = 8'h10; m_bank = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 fmt", {24'd0, fmt_ctrl}, 32'h10);
        check("R1 bank", {31'd0, bank_sel}, 32'd0);
        check("R1 valid", {31'd0, pix_rgb_valid}, 32'd0);
        check("R1 rgb", {8'd0, pix_rgb}, 32'd0);

        // R2 R3 stream a whole palette after one address write
        host_wr(2'd0, 8'd0);
        for (int i = 0; i < 256; i++) begin
            host_wr(2'd1, 8'($urandom));
            host_wr(2'd1, 8'($urandom));
            host_wr(2'd1, 8'($urandom));
        end
        for (int i = 0; i < 40; i++) pixel("R2 indexed", $urandom);
        pixel("R2 index 0", 32'h0000_0000);
        pixel("R2 index 255", 32'hFFFF_FFFF);

        // R3 wrap from 255 back to 0
        host_wr(2'd1, 8'hA1); host_wr(2'd1, 8'hB2); host_wr(2'd1, 8'hC3);
        pixel("R3 wrap entry 0", 32'h0000_0000);
        check("R3 wrap model", {8'd0, m_pal[0]}, 32'h00A1B2C3);

        // R4 partial triple dropped by address write
        old_val = m_pal[5];
        host_wr(2'd0, 8'd5); host_wr(2'd1, 8'h11); host_wr(2'd1, 8'h22);
        host_wr(2'd0, 8'd9);
        host_wr(2'd1, 8'h33); host_wr(2'd1, 8'h44); host_wr(2'd1, 8'h55);
        pixel("R4 entry 9", 32'h0000_0009);
        pixel("R4 entry 5 untouched", 32'h0000_0005);
        check("R4 entry 5 model", {8'd0, m_pal[5]}, {8'd0, old_val});

        // R5 R8 5-5-5 format
        set_reg(8'h20, 8'h14);
        check("R5 fmt 0x14", {24'd0, fmt_ctrl}, 32'h14);
        pixel("R8 all ones", 32'hFFFF_7FFF);
        pixel("R8 red only", 32'h0000_7C00);
        for (int i = 0; i < 30; i++) pixel("R8 rgb555", $urandom);

        // R5 R9 8-8-8 format, alpha ignored
        set_reg(8'h20, 8'h28);
        check("R5 fmt 0x28", {24'd0, fmt_ctrl}, 32'h28);
        pixel("R9 alpha set", 32'hFF12_3456);
        pixel("R9 alpha clear", 32'h0012_3456);
        for (int i = 0; i < 30; i++) pixel("R9 rgb888", $urandom);

        // R5 other encodings
        set_reg(8'h20, 8'h24);
        pixel("R5 0x24 is 555", 32'h0000_1234);
        set_reg(8'h20, 8'h1C);
        for (int i = 0; i < 10; i++) pixel("R5 0x1C is indexed", $urandom);
        set_reg(8'h20, 8'h20);
        for (int i = 0; i < 10; i++) pixel("R5 0x20 is indexed", $urandom);

        // R6 bank select
        set_reg(8'h21, 8'h01);
        check("R6 bank set", {31'd0, bank_sel}, 32'd1);
        set_reg(8'h21, 8'hFE);
        check("R6 bank clear", {31'd0, bank_sel}, 32'd0);
        set_reg(8'h21, 8'h03);

        // R7 other registers and unused port ignored
        set_reg(8'h10, 8'h00);
        set_reg(8'h11, 8'h00);
        set_reg(8'h22, 8'h18);
        host_wr(2'd3, 8'h14);
        check("R7 fmt kept", {24'd0, fmt_ctrl}, 32'h20);
        check("R7 bank kept", {31'd0, bank_sel}, 32'd1);
        pixel("R7 still indexed", 32'h0000_0009);

        // R10 idle output
        @(negedge clk);
        check("R10 idle valid", {31'd0, pix_rgb_valid}, 32'd0);
        check("R10 idle rgb", {8'd0, pix_rgb}, 32'd0);

        // R11 commit and lookup of one entry on the same edge
        host_wr(2'd0, 8'h40);
        host_wr(2'd1, 8'h0F); host_wr(2'd1, 8'hF0);
        old_val = m_pal[8'h40];
        host_wr_en = 1'b1; host_sel = 2'd1; host_wdata = 8'h5A;
        pix_valid = 1'b1; pix_data = 32'h0000_0040;
        @(negedge clk);
        host_wr_en = 1'b0; pix_valid = 1'b0;
        check("R11 same edge old", {8'd0, pix_rgb}, {8'd0, old_val});
        model_write(2'd1, 8'h5A);
        pixel("R11 next edge new", 32'h0000_0040);
        check("R11 new model", {8'd0, m_pal[8'h40]}, 32'h000FF05A);

        // R2 R3 random partial reloads mixed with lookups
        for (int i = 0; i < 20; i++) begin
            host_wr(2'd0, 8'($urandom));
            for (int k = 0; k < 6; k++) host_wr(2'd1, 8'($urandom));
            pixel("R3 reload lookup", {24'd0, m_addr - 8'd1});
            pixel("R2 reload lookup", {24'd0, m_addr - 8'd2});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule